// File: doc/BRIEF.md
# Configurable 64-bit timer with watchdog

This block is a counter built from two equal halves that can run as one wide general-purpose timer, as two independent timers, as a low-half prescaler feeding a high-half counter, or as a watchdog. In the general-purpose modes each half compares its count against a period input. On a match it returns to zero and raises a one-cycle interrupt pulse and a one-cycle DMA event pulse. The count advances either on every clock or on rising edges of an asynchronous external input. A rising edge of that input can also copy the whole count into a capture register. A read strobe can clear the count, so that a read-and-restart interval measurement needs no second access.

In watchdog mode the count runs against the full-width period. Software must service it by writing a first key and then a second key. A timeout, or any key out of sequence, asserts a reset request that stays asserted until the block's own reset. The watchdog is controlled by a four-state machine: WD_OFF, WD_WAIT, WD_HALF and WD_BITE. Its transitions are:
- ARM: WD_OFF to WD_WAIT when watchdog mode is selected and run is high.
- FIRST_KEY: WD_WAIT to WD_HALF.
- SERVICE: WD_HALF to WD_WAIT, which also clears the count.
- BAD_KEY: WD_WAIT or WD_HALF to WD_BITE.
- TIMEOUT: WD_WAIT or WD_HALF to WD_BITE.
- HOLD: WD_BITE to WD_BITE.

Top module: `tmr64_wd`

## Requirements
- R1: After reset, `cnt_o`, `cap_o`, `irq_o`, `dma_o` and `wd_rst_o` are all zero.
- R2: With `mode_i`=0 (wide), `cnt_o` counts as one 2*HW-bit value, carrying from the low half (bits HW-1:0) into the high half. The edge at which it equals {`prd_hi_i`,`prd_lo_i`} returns it to zero. In the following cycle bit 0 of `irq_o` and bit 0 of `dma_o` are high for exactly one cycle.
- R3: With `mode_i`=1 (dual), each half counts on every tick and wraps at its own period (`prd_lo_i` for the low half, `prd_hi_i` for the high half). A low wrap pulses bit 0 of `irq_o`/`dma_o`, and a high wrap pulses bit 1.
- R4: With `mode_i`=2 (chained), the low half wraps at `prd_lo_i` and pulses bit 0 of `irq_o`. Each low wrap advances the high half by one. When the high half wraps at `prd_hi_i`, bit 1 of `irq_o` pulses.
- R5: With `ext_sel_i`=1, the count advances once per rising edge of `ext_i`. That input passes through two synchronizing flops, so the increment appears three clock edges after the input rises. A held level does not advance the count.
- R6: In the general-purpose modes, the count holds its value while `run_i` is low.
- R7: With `cap_en_i`=1, a synchronized rising edge of `ext_i` copies the count into `cap_o`. At all other times `cap_o` keeps its value.
- R8: When `rdclr_en_i`=1, a cycle with `rd_i` high clears both halves at the next edge. With `rdclr_en_i`=0, `rd_i` has no effect.
- R9: With `mode_i`=3, the watchdog arms when `run_i` is high. The edge at which the count equals the full period without service asserts `wd_rst_o`, and it stays high until `rst_n` is asserted.
- R10: A key write of 16'hA5C3 followed by a key write of 16'h5A3C clears the watchdog count at the second write's edge and keeps `wd_rst_o` low.
- R11: Any key write that does not match the expected key for the current state asserts `wd_rst_o` at that edge.
- R12: Once the watchdog is armed, changing `mode_i` or lowering `run_i` neither stops nor disarms it, and `irq_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 wide, 1 dual, 2 chained, 3 watchdog |
| run_i | input | 1 | Count enable / watchdog arm |
| ext_sel_i | input | 1 | Count external rising edges instead of clocks |
| cap_en_i | input | 1 | Enable capture on external rising edge |
| rdclr_en_i | input | 1 | Enable clear-on-read |
| rd_i | input | 1 | Counter read strobe |
| ext_i | input | 1 | Asynchronous external clock/event input |
| prd_lo_i | input | HW | Low-half period |
| prd_hi_i | input | HW | High-half period |
| wd_wr_i | input | 1 | Watchdog key write strobe |
| wd_key_i | input | KW | Watchdog key value |
| cnt_o | output | 2*HW | Current count {high, low} |
| cap_o | output | 2*HW | Captured count |
| irq_o | output | 2 | Interrupt pulses (bit 0 low/wide, bit 1 high) |
| dma_o | output | 2 | DMA event pulses, same timing as irq_o |
| wd_rst_o | output | 1 | Watchdog reset request |

## Verification
The assertions assume that the periods are held steady while a count is running. They also assume that `ext_i` is the only asynchronous input, and that every other input changes only between clock edges. The bench drives every input on the falling clock edge, sets each period before raising run, and starts each scenario from a fresh reset. External pulses are held for three clock cycles high and three low, so that every edge survives the two-flop synchronizer.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_WIDE  = 2'd0,
        MODE_DUAL  = 2'd1,
        MODE_CHAIN = 2'd2,
        MODE_WDOG  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_WAIT = 2'd1,
        WD_HALF = 2'd2,
        WD_BITE = 2'd3
    } wd_state_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise_o = s2_q && !s3_q;

    // R5
    rise_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         wrap_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i || (inc_i && wrap_i))
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_wdog_fsm.sv
module tmr_wdog_fsm
    import tmr_pkg::*;
#(
    parameter int            KW    = 16,
    parameter logic [KW-1:0] KEY_A = 16'hA5C3,
    parameter logic [KW-1:0] KEY_B = 16'h5A3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          wr_i,
    input  logic [KW-1:0] key_i,
    input  logic          timeout_i,
    output logic          armed_o,
    output logic          counting_o,
    output logic          svc_o,
    output logic          bite_o
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= WD_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (arm_i) state_d = WD_WAIT;
            WD_WAIT: begin
                if (timeout_i || (wr_i && key_i != KEY_A)) state_d = WD_BITE;
                else if (wr_i)                             state_d = WD_HALF;
            end
            WD_HALF: begin
                if (timeout_i || (wr_i && key_i != KEY_B)) state_d = WD_BITE;
                else if (wr_i)                             state_d = WD_WAIT;
            end
            WD_BITE: state_d = WD_BITE;
            default: state_d = WD_OFF;
        endcase
    end

    always_comb begin
        armed_o    = (state_q != WD_OFF);
        counting_o = (state_q == WD_WAIT) || (state_q == WD_HALF);
        svc_o      = (state_q == WD_HALF) && wr_i && (key_i == KEY_B) && !timeout_i;
        bite_o     = (state_q == WD_BITE);
    end

    // R9
    bite_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bite_o |=> bite_o);
    // R11
    bad_first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counting_o && !svc_o && wr_i && key_i != KEY_A && key_i != KEY_B) |=> bite_o);
endmodule

// File: rtl/tmr64_wd.sv
module tmr64_wd
    import tmr_pkg::*;
#(
    parameter int            HW    = 32,
    parameter int            KW    = 16,
    parameter logic [KW-1:0] KEY_A = 16'hA5C3,
    parameter logic [KW-1:0] KEY_B = 16'h5A3C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic            run_i,
    input  logic            ext_sel_i,
    input  logic            cap_en_i,
    input  logic            rdclr_en_i,
    input  logic            rd_i,
    input  logic            ext_i,
    input  logic [HW-1:0]   prd_lo_i,
    input  logic [HW-1:0]   prd_hi_i,
    input  logic            wd_wr_i,
    input  logic [KW-1:0]   wd_key_i,
    output logic [2*HW-1:0] cnt_o,
    output logic [2*HW-1:0] cap_o,
    output logic [1:0]      irq_o,
    output logic [1:0]      dma_o,
    output logic            wd_rst_o
);
    localparam int CW = 2 * HW;

    tmr_mode_e     mode;
    logic          rise, src, gp, tick, wide, rd_clr, clr, timeout;
    logic          wd_armed, wd_counting, wd_svc, wd_bite;
    logic          lo_hit, hi_hit, full_hit, lo_ones;
    logic [1:0]    inc, wrap, irq_set, irq_q;
    logic [HW-1:0] cnt_h [2];
    logic [HW-1:0] cnt_lo, cnt_hi;
    logic [CW-1:0] cap_q;

    assign mode = tmr_mode_e'(mode_i);

    tmr_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_i),
        .rise_o (rise)
    );

    for (genvar i = 0; i < 2; i++) begin : g_half
        tmr_half #(.W(HW)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc[i]),
            .wrap_i(wrap[i]),
            .clr_i (clr),
            .cnt_o (cnt_h[i])
        );
    end

    assign cnt_lo   = cnt_h[0];
    assign cnt_hi   = cnt_h[1];
    assign lo_hit   = (cnt_lo == prd_lo_i);
    assign hi_hit   = (cnt_hi == prd_hi_i);
    assign full_hit = lo_hit && hi_hit;
    assign lo_ones  = &cnt_lo;

    assign src     = ext_sel_i ? rise : 1'b1;
    assign gp      = !wd_armed && (mode != MODE_WDOG);
    assign tick    = src && (gp ? run_i : wd_counting);
    assign wide    = wd_armed || (mode == MODE_WIDE) || (mode == MODE_WDOG);
    assign rd_clr  = gp && rdclr_en_i && rd_i;
    assign clr     = rd_clr || wd_svc;
    assign timeout = tick && wd_counting && full_hit;

    tmr_wdog_fsm #(.KW(KW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     ((mode == MODE_WDOG) && run_i),
        .wr_i      (wd_wr_i),
        .key_i     (wd_key_i),
        .timeout_i (timeout),
        .armed_o   (wd_armed),
        .counting_o(wd_counting),
        .svc_o     (wd_svc),
        .bite_o    (wd_bite)
    );

    always_comb begin
        inc     = '0;
        wrap    = '0;
        irq_set = '0;
        if (wide) begin
            inc[0]  = tick;
            inc[1]  = tick && (full_hit || lo_ones);
            wrap    = {full_hit, full_hit};
            irq_set = {1'b0, gp && tick && full_hit};
        end else if (mode == MODE_CHAIN) begin
            inc[0]  = tick;
            inc[1]  = tick && lo_hit;
            wrap    = {hi_hit, lo_hit};
            irq_set = {tick && lo_hit && hi_hit, tick && lo_hit};
        end else begin
            inc     = {tick, tick};
            wrap    = {hi_hit, lo_hit};
            irq_set = {tick && hi_hit, tick && lo_hit};
        end
        if (clr) irq_set = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            cap_q <= '0;
        end else begin
            irq_q <= irq_set;
            if (cap_en_i && rise) cap_q <= {cnt_hi, cnt_lo};
        end
    end

    assign cnt_o    = {cnt_hi, cnt_lo};
    assign cap_o    = cap_q;
    assign irq_o    = irq_q;
    assign dma_o    = irq_q;
    assign wd_rst_o = wd_bite;

    // R2
    irq_zero_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[0] |-> (cnt_lo == '0));
    // R3
    irq_zero_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[1] |-> (cnt_hi == '0));
    // R6
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wd_armed && !rd_clr) |=> $stable(cnt_o));
    // R7
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en_i && rise) |=> $stable(cap_q));
    // R12
    wd_quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_armed |=> (irq_q == 2'b00));
endmodule

// File: tb/sim_tmr64_wd.sv
module sim_tmr64_wd;
    localparam int HW = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      mode_i;
    logic            run_i, ext_sel_i, cap_en_i, rdclr_en_i, rd_i, ext_i, wd_wr_i;
    logic [HW-1:0]   prd_lo_i, prd_hi_i;
    logic [15:0]     wd_key_i;
    logic [2*HW-1:0] cnt_o, cap_o;
    logic [1:0]      irq_o, dma_o;
    logic            wd_rst_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tmr64_wd #(.HW(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .run_i(run_i),
        .ext_sel_i(ext_sel_i), .cap_en_i(cap_en_i), .rdclr_en_i(rdclr_en_i),
        .rd_i(rd_i), .ext_i(ext_i), .prd_lo_i(prd_lo_i), .prd_hi_i(prd_hi_i),
        .wd_wr_i(wd_wr_i), .wd_key_i(wd_key_i), .cnt_o(cnt_o), .cap_o(cap_o),
        .irq_o(irq_o), .dma_o(dma_o), .wd_rst_o(wd_rst_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; mode_i = 2'd0; run_i = 0; ext_sel_i = 0; cap_en_i = 0;
        rdclr_en_i = 0; rd_i = 0; ext_i = 0; wd_wr_i = 0; wd_key_i = '0;
        prd_lo_i = '0; prd_hi_i = '0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        do_reset();
        check("R1 cnt", cnt_o, 0);
        check("R1 cap", cap_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 dma", dma_o, 0);
        check("R1 wdrst", wd_rst_o, 0);
    endtask

    task automatic t_wide;
        do_reset();
        mode_i = 2'd0; prd_hi_i = 8'h01; prd_lo_i = 8'h02; run_i = 1;
        step(255);
        check("R2 count 255", cnt_o, 16'h00FF);
        step(1);
        check("R2 carry into high half", cnt_o, 16'h0100);
        step(2);
        check("R2 at period", cnt_o, 16'h0102);
        check("R2 no irq before wrap", irq_o, 0);
        step(1);
        check("R2 wrapped", cnt_o, 0);
        check("R2 irq pulse", irq_o, 2'b01);
        check("R2 dma pulse", dma_o, 2'b01);
        step(1);
        check("R2 irq one cycle", irq_o, 0);
        check("R2 counting on", cnt_o, 1);
        run_i = 0;
        step(5);
        check("R6 held while stopped", cnt_o, 1);
    endtask

    task automatic t_dual;
        do_reset();
        mode_i = 2'd1; prd_lo_i = 8'd3; prd_hi_i = 8'd5; run_i = 1;
        for (int k = 1; k <= 12; k++) begin
            step(1);
            check("R3 dual count", cnt_o, ((k % 6) << 8) | (k % 4));
            check("R3 dual irq", irq_o, {(k % 6) == 0, (k % 4) == 0});
        end
    endtask

    task automatic t_chain;
        do_reset();
        mode_i = 2'd2; prd_lo_i = 8'd2; prd_hi_i = 8'd3; run_i = 1;
        for (int k = 1; k <= 24; k++) begin
            step(1);
            check("R4 chain count", cnt_o, (((k / 3) % 4) << 8) | (k % 3));
            check("R4 chain irq", irq_o, {(k % 12) == 0, (k % 3) == 0});
        end
    endtask

    task automatic t_ext;
        do_reset();
        mode_i = 2'd0; prd_lo_i = 8'hFF; prd_hi_i = 8'hFF; ext_sel_i = 1; run_i = 1;
        for (int p = 0; p < 5; p++) begin
            ext_i = 1; step(3);
            ext_i = 0; step(3);
        end
        step(3);
        check("R5 five external edges", cnt_o, 5);
        ext_i = 1;
        step(2);
        check("R5 not yet through synchronizer", cnt_o, 5);
        step(1);
        check("R5 third edge increments", cnt_o, 6);
        step(10);
        check("R5 held level no count", cnt_o, 6);
    endtask

    task automatic t_capture;
        do_reset();
        mode_i = 2'd1; prd_lo_i = 8'hFF; prd_hi_i = 8'hFF; cap_en_i = 1; run_i = 1;
        step(4);
        ext_i = 1;
        step(3);
        check("R7 captured count", cap_o, 16'h0606);
        step(5);
        check("R7 held high no recapture", cap_o, 16'h0606);
        cap_en_i = 0; ext_i = 0;
        step(3);
        ext_i = 1;
        step(4);
        check("R7 disabled no capture", cap_o, 16'h0606);
    endtask

    task automatic t_rdclr;
        do_reset();
        mode_i = 2'd0; prd_lo_i = 8'hFF; prd_hi_i = 8'hFF; run_i = 1;
        step(10);
        check("R8 before read", cnt_o, 10);
        rd_i = 1;
        step(1);
        rd_i = 0;
        check("R8 read without enable ignored", cnt_o, 11);
        rdclr_en_i = 1; rd_i = 1;
        step(1);
        rd_i = 0;
        check("R8 read clears", cnt_o, 0);
        step(2);
        check("R8 restarts", cnt_o, 2);
    endtask

    task automatic t_wd_timeout;
        do_reset();
        mode_i = 2'd3; prd_lo_i = 8'd5; prd_hi_i = 8'd0; run_i = 1;
        step(6);
        check("R9 count at period", cnt_o, 5);
        check("R9 no bite yet", wd_rst_o, 0);
        step(1);
        check("R9 timeout bites", wd_rst_o, 1);
        run_i = 0; mode_i = 2'd0;
        step(5);
        check("R9 bite sticky", wd_rst_o, 1);
    endtask

    task automatic t_wd_service;
        do_reset();
        mode_i = 2'd3; prd_lo_i = 8'd5; prd_hi_i = 8'd0; run_i = 1;
        step(4);
        wd_wr_i = 1; wd_key_i = 16'hA5C3;
        step(1);
        check("R10 first key no bite", wd_rst_o, 0);
        wd_key_i = 16'h5A3C;
        step(1);
        wd_wr_i = 0;
        check("R10 service clears count", cnt_o, 0);
        check("R10 service no bite", wd_rst_o, 0);
        step(5);
        check("R10 counting after service", cnt_o, 5);
        check("R10 still alive", wd_rst_o, 0);
        step(1);
        check("R10 later timeout", wd_rst_o, 1);
    endtask

    task automatic t_wd_badkey;
        do_reset();
        mode_i = 2'd3; prd_lo_i = 8'd50; run_i = 1;
        step(2);
        wd_wr_i = 1; wd_key_i = 16'h1234;
        step(1);
        wd_wr_i = 0;
        check("R11 wrong first key bites", wd_rst_o, 1);
        do_reset();
        mode_i = 2'd3; prd_lo_i = 8'd50; run_i = 1;
        step(2);
        wd_wr_i = 1; wd_key_i = 16'hA5C3;
        step(1);
        check("R11 first key accepted", wd_rst_o, 0);
        step(1);
        wd_wr_i = 0;
        check("R11 repeated first key bites", wd_rst_o, 1);
    endtask

    task automatic t_wd_locked;
        do_reset();
        mode_i = 2'd3; prd_lo_i = 8'd5; run_i = 1;
        step(3);
        run_i = 0; mode_i = 2'd0;
        step(3);
        check("R12 keeps counting after run low", cnt_o, 5);
        check("R12 no irq in watchdog", irq_o, 0);
        check("R12 not yet bitten", wd_rst_o, 0);
        step(1);
        check("R12 still times out", wd_rst_o, 1);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_wide();
        t_dual();
        t_chain();
        t_ext();
        t_capture();
        t_rdclr();
        t_wd_timeout();
        t_wd_service();
        t_wd_badkey();
        t_wd_locked();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule